// File: doc/BRIEF.md
# Supply-Fail Write Protection Controller

This block supervises a battery-backed byte-wide memory. External comparators report where the main supply sits against four thresholds, and the block turns those flags into the memory's protection controls. While the supply is good, host write and read requests pass straight through to the array. When the supply sags below the write-protect trip point, writes are cut off in the same cycle, a write already under way is aborted, inputs are gated and the data outputs go high-impedance. Normal operation comes back only once the supply climbs above a higher full-function level. This gap is the hysteresis.

If the supply falls further, below roughly 3.0 V, the block selects the backup battery for the array. It hands the array back to main power when the supply recovers past that point. A one-time seal keeps the battery path disconnected from the first reset until the supply has first been seen above the trip level. After that, battery backup stays armed for good. A build-time parameter picks the tolerance variant, which decides which two flags act as the trip and resume points. Each flag passes through a two-stage synchronizer and a persistence filter before it can change the state.

Top module: `supply_fail_guard`

## Requirements
- R1: After reset, `state_o` is 2'b00 (sealed), and `wr_protect_o`, `in_gate_o` and `out_hiz_o` are 1, while `batt_sel_o`, `wr_abort_o` and `mem_we_o` are 0.
- R2: Flag bits of `sup_lvl_i` are 1 when the supply is above a threshold: bit0 is about 3.0 V, bit1 is 4.25 V, bit2 is 4.5 V and bit3 is 4.75 V. Each flag is synchronized by two flops. It is accepted only after it has held a new level for FILT_CYCLES cycles, so a change applied before clock edge 0 reaches `wr_protect_o` after edge FILT_CYCLES+1 and reaches `state_o` one edge later. A pulse shorter than FILT_CYCLES cycles has no effect.
- R3: In the sealed state (00), `batt_sel_o` stays 0 whatever the flags show. The first accepted trip flag moves the state to protected (2'b10), and the state never returns to sealed before reset.
- R4: The protected state moves to normal (2'b01) only when the resume flag is accepted. A supply above the trip point but below the resume point keeps the state protected.
- R5: In normal, `wr_protect_o` rises in the same cycle that the filtered trip flag falls, while `state_o` still reads normal. The state reads protected one cycle later.
- R6: If `wr_req_i` is 1 in the cycle protection asserts out of normal, `wr_abort_o` is 1 for exactly that one cycle and `mem_we_o` is 0. If `wr_req_i` is 0 in that cycle, no abort pulse occurs.
- R7: In every state other than normal, `mem_we_o` is 0 regardless of `wr_req_i`, and `in_gate_o` and `out_hiz_o` are 1 regardless of `rd_req_i`.
- R8: From protected, an accepted low switchover flag (bit0) gives the battery state (2'b11) with `batt_sel_o` = 1. An accepted high bit0 returns the state to protected with `batt_sel_o` = 0. The battery state is entered only from protected.
- R9: In normal, `mem_we_o` follows `wr_req_i`, `in_gate_o` is 0 and `out_hiz_o` is the inverse of `rd_req_i`.
- R10: With WIDE_TOL = 0, bit2 is the trip flag and bit3 the resume flag. With WIDE_TOL = 1, bit1 is the trip flag and bit2 the resume flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_lvl_i | input | 4 | Asynchronous comparator flags, one per threshold |
| wr_req_i | input | 1 | Host write strobe |
| rd_req_i | input | 1 | Host read strobe |
| mem_we_o | output | 1 | Gated write enable to the array |
| wr_protect_o | output | 1 | Write protection active |
| in_gate_o | output | 1 | Array inputs ignored |
| out_hiz_o | output | 1 | Data outputs high-impedance |
| batt_sel_o | output | 1 | Battery powers the array |
| wr_abort_o | output | 1 | One-cycle pulse: a write was cut off |
| state_o | output | 2 | 00 sealed, 01 normal, 10 protected, 11 battery |

## Verification
Protection assertion and write abort can coincide: the cycle in which the filtered trip flag falls is also the last cycle the state reads normal. The bench keeps `wr_req_i` high, drops the trip flag, and samples the exact cycle predicted by the filter latency. In that cycle it expects `wr_protect_o` and `wr_abort_o` both high, `mem_we_o` low and `state_o` still normal. It then expects the abort gone and the state protected one cycle later. A second trip with the write strobe low must produce protection with no abort at all.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  // Position of each comparator flag within the level vector
  localparam int LVL_SWITCH = 0;  // about 3.0 V, battery switchover
  localparam int LVL_LOW    = 1;  // 4.25 V
  localparam int LVL_MID    = 2;  // 4.5 V
  localparam int LVL_HIGH   = 3;  // 4.75 V
  localparam int LVL_COUNT  = 4;

  typedef enum logic [1:0] {
    ST_SEALED = 2'b00,
    ST_NORMAL = 2'b01,
    ST_PROT   = 2'b10,
    ST_BATT   = 2'b11
  } sfg_state_e;
endpackage

// File: rtl/sfg_flag_filter.sv
module sfg_flag_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CNT_W   = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
  localparam int CNT_TOP = FILT_CYCLES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   filt_q;

  // Synchronizer chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  // Persistence counter: the synchronized level must differ from the
  // accepted level for FILT_CYCLES consecutive cycles before it is taken.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (sync_q[SYNC_STAGES-1] == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_W'(CNT_TOP)) begin
      cnt_q  <= '0;
      filt_q <= sync_q[SYNC_STAGES-1];
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/sfg_level_select.sv
module sfg_level_select
  import sfg_pkg::*;
#(
  parameter bit WIDE_TOL = 1'b0
) (
  input  logic [LVL_COUNT-1:0] lvl_f_i,
  output logic                 trip_ok_o,
  output logic                 resume_ok_o,
  output logic                 main_ok_o
);
  localparam int TRIP_IDX   = WIDE_TOL ? LVL_LOW : LVL_MID;
  localparam int RESUME_IDX = WIDE_TOL ? LVL_MID : LVL_HIGH;

  assign trip_ok_o   = lvl_f_i[TRIP_IDX];
  assign resume_ok_o = lvl_f_i[RESUME_IDX];
  assign main_ok_o   = lvl_f_i[LVL_SWITCH];
endmodule

// File: rtl/sfg_fsm.sv
module sfg_fsm
  import sfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trip_ok_i,
  input  logic       resume_ok_i,
  input  logic       main_ok_i,
  input  logic       wr_req_i,
  input  logic       rd_req_i,
  output logic       mem_we_o,
  output logic       wr_protect_o,
  output logic       in_gate_o,
  output logic       out_hiz_o,
  output logic       batt_sel_o,
  output logic       wr_abort_o,
  output logic [1:0] state_o
);
  sfg_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SEALED: if (trip_ok_i) state_d = ST_PROT;
      ST_NORMAL: if (!trip_ok_i) state_d = ST_PROT;
      ST_PROT: begin
        if (!main_ok_i)                   state_d = ST_BATT;
        else if (trip_ok_i && resume_ok_i) state_d = ST_NORMAL;
      end
      ST_BATT:   if (main_ok_i) state_d = ST_PROT;
      default:   state_d = ST_SEALED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_SEALED;
    else        state_q <= state_d;
  end

  logic run_ok;
  // Protection bypasses the state register so a trip cuts writes at once
  assign run_ok       = (state_q == ST_NORMAL) && trip_ok_i;
  assign wr_protect_o = !run_ok;
  assign in_gate_o    = !run_ok;
  assign out_hiz_o    = !run_ok || !rd_req_i;
  assign mem_we_o     = run_ok && wr_req_i;
  assign wr_abort_o   = (state_q == ST_NORMAL) && !trip_ok_i && wr_req_i;
  assign batt_sel_o   = (state_q == ST_BATT);
  assign state_o      = state_q;
endmodule

// File: rtl/supply_fail_guard.sv
module supply_fail_guard
  import sfg_pkg::*;
#(
  parameter bit WIDE_TOL    = 1'b0,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LVL_COUNT-1:0] sup_lvl_i,
  input  logic                 wr_req_i,
  input  logic                 rd_req_i,
  output logic                 mem_we_o,
  output logic                 wr_protect_o,
  output logic                 in_gate_o,
  output logic                 out_hiz_o,
  output logic                 batt_sel_o,
  output logic                 wr_abort_o,
  output logic [1:0]           state_o
);
  logic [LVL_COUNT-1:0] lvl_f;
  logic trip_ok, resume_ok, main_ok;

  for (genvar g = 0; g < LVL_COUNT; g++) begin : g_flag
    sfg_flag_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYCLES(FILT_CYCLES)
    ) i_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (sup_lvl_i[g]),
      .filt_o (lvl_f[g])
    );
  end

  sfg_level_select #(.WIDE_TOL(WIDE_TOL)) i_sel (
    .lvl_f_i     (lvl_f),
    .trip_ok_o   (trip_ok),
    .resume_ok_o (resume_ok),
    .main_ok_o   (main_ok)
  );

  sfg_fsm i_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .trip_ok_i    (trip_ok),
    .resume_ok_i  (resume_ok),
    .main_ok_i    (main_ok),
    .wr_req_i     (wr_req_i),
    .rd_req_i     (rd_req_i),
    .mem_we_o     (mem_we_o),
    .wr_protect_o (wr_protect_o),
    .in_gate_o    (in_gate_o),
    .out_hiz_o    (out_hiz_o),
    .batt_sel_o   (batt_sel_o),
    .wr_abort_o   (wr_abort_o),
    .state_o      (state_o)
  );
endmodule

// File: rtl/sfg_checker.sv
module sfg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_req_i,
  input logic       rd_req_i,
  input logic       mem_we_o,
  input logic       wr_protect_o,
  input logic       in_gate_o,
  input logic       out_hiz_o,
  input logic       batt_sel_o,
  input logic       wr_abort_o,
  input logic [1:0] state_o
);
  // R3
  seal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'b00) |=> (state_o != 2'b00));

  // R3
  no_batt_sealed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b00) |-> !batt_sel_o);

  // R4
  normal_from_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b01 && $past(state_o) != 2'b01) |-> ($past(state_o) == 2'b10));

  // R5
  abort_to_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_abort_o |=> (state_o == 2'b10));

  // R6
  abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_abort_o |-> (wr_protect_o && wr_req_i && !mem_we_o) ##1 !wr_abort_o);

  // R7
  locked_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'b01) |-> (!mem_we_o && in_gate_o && out_hiz_o && wr_protect_o));

  // R8
  batt_from_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (batt_sel_o && !$past(batt_sel_o)) |-> ($past(state_o) == 2'b10));

  // R9
  read_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_hiz_o) |-> (rd_req_i && !in_gate_o));
endmodule

bind supply_fail_guard sfg_checker i_sfg_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_req_i     (wr_req_i),
  .rd_req_i     (rd_req_i),
  .mem_we_o     (mem_we_o),
  .wr_protect_o (wr_protect_o),
  .in_gate_o    (in_gate_o),
  .out_hiz_o    (out_hiz_o),
  .batt_sel_o   (batt_sel_o),
  .wr_abort_o   (wr_abort_o),
  .state_o      (state_o)
);

// File: tb/test_supply_fail_guard.sv
`timescale 1ns/1ps
module test_supply_fail_guard;
  localparam int FILT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] lvl = 4'b0000;
  logic       wr_req = 1'b0;
  logic       rd_req = 1'b0;

  logic       t_we, t_prot, t_gate, t_hiz, t_batt, t_abort;
  logic [1:0] t_st;
  logic       w_we, w_prot, w_gate, w_hiz, w_batt, w_abort;
  logic [1:0] w_st;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  supply_fail_guard #(.WIDE_TOL(1'b0), .FILT_CYCLES(FILT)) i_supply_fail_guard (
    .clk(clk), .rst_n(rst_n), .sup_lvl_i(lvl), .wr_req_i(wr_req), .rd_req_i(rd_req),
    .mem_we_o(t_we), .wr_protect_o(t_prot), .in_gate_o(t_gate), .out_hiz_o(t_hiz),
    .batt_sel_o(t_batt), .wr_abort_o(t_abort), .state_o(t_st));

  supply_fail_guard #(.WIDE_TOL(1'b1), .FILT_CYCLES(FILT)) i_wide (
    .clk(clk), .rst_n(rst_n), .sup_lvl_i(lvl), .wr_req_i(wr_req), .rd_req_i(rd_req),
    .mem_we_o(w_we), .wr_protect_o(w_prot), .in_gate_o(w_gate), .out_hiz_o(w_hiz),
    .batt_sel_o(w_batt), .wr_abort_o(w_abort), .state_o(w_st));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 state", t_st, 0);
    chk("R1 protect", t_prot, 1);
    chk("R1 gate", t_gate, 1);
    chk("R1 hiz", t_hiz, 1);
    chk("R1 batt", t_batt, 0);
    chk("R1 abort", t_abort, 0);
    chk("R1 we", t_we, 0);
  endtask

  task automatic t_seal;
    lvl = 4'b0000; step(12);
    chk("R3 sealed at 0V", t_st, 0);
    chk("R3 no battery while sealed", t_batt, 0);
    lvl = 4'b0001; step(12);
    chk("R3 sealed below trip", t_st, 0);
    lvl = 4'b0111; step(12);
    chk("R3 seal broken to protected", t_st, 2);
    chk("R10 wide resumes at bit2", w_st, 1);
  endtask

  task automatic t_hyst;
    wr_req = 1'b1; rd_req = 1'b1; step(12);
    chk("R4 trip alone keeps protected", t_st, 2);
    chk("R7 we blocked", t_we, 0);
    chk("R7 hiz while protected", t_hiz, 1);
    chk("R7 gate while protected", t_gate, 1);
    wr_req = 1'b0; rd_req = 1'b0;
  endtask

  task automatic t_resume;
    lvl = 4'b1111; step(FILT + 2);
    chk("R2 state not yet normal", t_st, 2);
    step(1);
    chk("R2 R4 normal after resume", t_st, 1);
  endtask

  task automatic t_normal;
    wr_req = 1'b1; rd_req = 1'b1; step(1);
    chk("R9 we follows req", t_we, 1);
    chk("R9 hiz low on read", t_hiz, 0);
    chk("R9 gate open", t_gate, 0);
    wr_req = 1'b0; rd_req = 1'b0; step(1);
    chk("R9 we low", t_we, 0);
    chk("R9 hiz high without read", t_hiz, 1);
  endtask

  task automatic t_glitch;
    int hits = 0;
    lvl = 4'b1011; step(FILT - 2);
    lvl = 4'b1111;
    for (int i = 0; i < 12; i++) begin
      step(1);
      if (t_prot) hits++;
    end
    chk("R2 short dip ignored", hits, 0);
    chk("R2 still normal", t_st, 1);
  endtask

  task automatic t_trip_abort;
    wr_req = 1'b1;
    lvl = 4'b0011; step(FILT + 1);
    chk("R2 protect not yet", t_prot, 0);
    step(1);
    chk("R5 protect same cycle", t_prot, 1);
    chk("R5 state still normal", t_st, 1);
    chk("R6 abort pulse", t_abort, 1);
    chk("R6 we cut", t_we, 0);
    step(1);
    chk("R5 protected next cycle", t_st, 2);
    chk("R6 abort one cycle", t_abort, 0);
    chk("R10 wide stays normal above bit1", w_st, 1);
    wr_req = 1'b0;
  endtask

  task automatic t_trip_quiet;
    int aborts = 0;
    lvl = 4'b0001;
    for (int i = 0; i < 12; i++) begin
      step(1);
      if (w_abort || t_abort) aborts++;
    end
    chk("R6 no abort without write", aborts, 0);
    chk("R10 wide trips below bit1", w_st, 2);
  endtask

  task automatic t_battery;
    wr_req = 1'b1;
    lvl = 4'b0000; step(12);
    chk("R8 battery state", t_st, 3);
    chk("R8 battery selected", t_batt, 1);
    chk("R3 seal not re-entered", t_st == 0, 0);
    chk("R7 we blocked on battery", t_we, 0);
    lvl = 4'b0001; step(12);
    chk("R8 back to protected", t_st, 2);
    chk("R8 battery released", t_batt, 0);
    lvl = 4'b1111; step(12);
    chk("R4 normal again", t_st, 1);
    chk("R9 we with request", t_we, 1);
    wr_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all requirements: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_seal();
    t_hyst();
    t_resume();
    t_normal();
    t_glitch();
    t_trip_abort();
    t_trip_quiet();
    t_battery();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule